// File: doc/BRIEF.md
# Loss-of-Clock Supervisor and Source Selector

This block watches two clock sources from a free-running supervisory clock: the reference input and the PLL feedback clock, which are the two inputs of the phase-frequency detector. Each source arrives as a one-cycle edge indication. An activity monitor counts supervisory cycles without an edge. When a count reaches the window length, that source is declared dead.

A selector then chooses the system clock source and holds that choice until reset. If the PLL dies, the block falls back to the reference. If the reference dies, alone or together with the PLL, the reference loss wins and the block moves to self-clocked mode. It drops to a static no-clock state if self-clocked operation reports itself unhealthy. Sticky status flags and an optional interrupt request record the failure.

A reset-release permission tells the reset controller whether both sources are currently alive. The clock multiplexer and the output divider lie outside this block. The divider field sets the self-clocked frequency, and the nominal frequency applies when that field is 000. The block only produces a select code for them.

Top module: `clk_loss_supervisor`

## Requirements
- R1: After reset, sel_o is 2'b00 in PLL mode (ext_mode_i=0) or 2'b01 in external mode (ext_mode_i=1). irq_o, ref_lost_o and pll_lost_o are 0.
- R2: A source is dead after WIN_CYCLES (default 256) consecutive supervisory cycles with no edge. The select output and the flags update on the next clock edge after that. Nothing changes after WIN_CYCLES-1 silent cycles.
- R3: When supervision is active and the reference dies while self-clocked mode is healthy (scm_ok_i=1), sel_o becomes 2'b10 and ref_lost_o sets. The block stays in that state after the reference returns.
- R4: When supervision is active and only the PLL dies, sel_o becomes 2'b01 and pll_lost_o sets. That choice holds until reset, even after PLL edges resume.
- R5: In a double failure the reference loss has priority, and sel_o becomes 2'b10 with scm_ok_i=1. This holds whether both die together or the PLL dies first, in which case the code passes through 2'b01.
- R6: If scm_ok_i is 0 when a reference loss is acted on, or falls while sel_o is 2'b10, sel_o becomes 2'b11 and stays there until reset.
- R7: irq_o sets on a detected loss only when irq_en_i=1, loc_en_i=1 and ext_mode_i=0. Once set, it stays high until reset.
- R8: ref_lost_o and pll_lost_o are sticky and only reset clears them.
- R9: With ext_mode_i=1 or loc_en_i=0, sel_o stays at its R1 default and no flag or interrupt sets, even when both sources stop.
- R10: rst_release_o is 1 only while neither source is dead. It falls after WIN_CYCLES silent cycles and rises one cycle after edges resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running supervisory clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_edge_i | input | 1 | Edge seen on reference clock this cycle |
| fb_edge_i | input | 1 | Edge seen on PLL feedback clock this cycle |
| ext_mode_i | input | 1 | 1: external clock mode, 0: PLL mode |
| loc_en_i | input | 1 | Loss-of-clock supervision enable |
| irq_en_i | input | 1 | Loss-of-clock interrupt enable |
| scm_ok_i | input | 1 | Self-clocked mode is able to run |
| sel_o | output | 2 | Source select: 00 PLL, 01 reference, 10 self-clocked, 11 static |
| irq_o | output | 1 | Sticky loss-of-clock interrupt request |
| ref_lost_o | output | 1 | Sticky reference-loss flag |
| pll_lost_o | output | 1 | Sticky PLL-loss flag |
| rst_release_o | output | 1 | Both sources currently alive |

## Verification
The monitors count from the first silent cycle. The dead indication, and with it rst_release_o, follows after exactly WIN_CYCLES clock edges, and the select code, flags and interrupt follow one edge later. The bench changes inputs on falling edges. It queues expectations at the falling edge after WIN_CYCLES-1, WIN_CYCLES and WIN_CYCLES+1 edges, so each boundary is seen from both sides. Recovery checks wait one edge for rst_release_o and several more edges to show that the latched select does not move.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;
  typedef enum logic [1:0] {
    SEL_PLL    = 2'b00,
    SEL_REF    = 2'b01,
    SEL_SCM    = 2'b10,
    SEL_STATIC = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    ST_NORMAL,
    ST_ON_REF,
    ST_ON_SCM,
    ST_HALTED
  } sup_state_e;
endpackage

// File: rtl/clk_loss_activity_mon.sv
module clk_loss_activity_mon #(
  parameter int unsigned WIN_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic dead_o
);
  localparam int unsigned CntW = $clog2(WIN_CYCLES + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(WIN_CYCLES);

  logic [CntW-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             quiet_q <= '0;
    else if (edge_i)         quiet_q <= '0;
    else if (quiet_q != CntMax) quiet_q <= quiet_q + 1'b1;
  end

  assign dead_o = (quiet_q == CntMax);
endmodule

// File: rtl/clk_loss_select_fsm.sv
module clk_loss_select_fsm
  import clk_loss_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_dead_i,
  input  logic       fb_dead_i,
  input  logic       ext_mode_i,
  input  logic       loc_en_i,
  input  logic       irq_en_i,
  input  logic       scm_ok_i,
  output clk_sel_e   sel_o,
  output logic       irq_o,
  output logic       ref_lost_o,
  output logic       pll_lost_o
);
  sup_state_e state_q, state_d;
  logic active;
  logic ref_hit, fb_hit;

  assign active  = loc_en_i & ~ext_mode_i;
  assign ref_hit = active & ref_dead_i;
  assign fb_hit  = active & fb_dead_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        // reference loss outranks PLL loss
        if (ref_hit)     state_d = scm_ok_i ? ST_ON_SCM : ST_HALTED;
        else if (fb_hit) state_d = ST_ON_REF;
      end
      ST_ON_REF: if (ref_hit) state_d = scm_ok_i ? ST_ON_SCM : ST_HALTED;
      ST_ON_SCM: if (!scm_ok_i) state_d = ST_HALTED;
      default:   state_d = ST_HALTED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_NORMAL;
      ref_lost_o <= 1'b0;
      pll_lost_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_lost_o <= ref_lost_o | ref_hit;
      pll_lost_o <= pll_lost_o | fb_hit;
      irq_o      <= irq_o | (irq_en_i & (ref_hit | fb_hit));
    end
  end

  always_comb begin
    unique case (state_q)
      ST_NORMAL: sel_o = ext_mode_i ? SEL_REF : SEL_PLL;
      ST_ON_REF: sel_o = SEL_REF;
      ST_ON_SCM: sel_o = SEL_SCM;
      default:   sel_o = SEL_STATIC;
    endcase
  end
endmodule

// File: rtl/clk_loss_supervisor.sv
module clk_loss_supervisor
  import clk_loss_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_edge_i,
  input  logic       fb_edge_i,
  input  logic       ext_mode_i,
  input  logic       loc_en_i,
  input  logic       irq_en_i,
  input  logic       scm_ok_i,
  output logic [1:0] sel_o,
  output logic       irq_o,
  output logic       ref_lost_o,
  output logic       pll_lost_o,
  output logic       rst_release_o
);
  localparam int unsigned NumSrc = 2;

  logic [NumSrc-1:0] edge_vec;
  logic [NumSrc-1:0] dead_vec;
  clk_sel_e          sel;

  assign edge_vec = {fb_edge_i, ref_edge_i};

  for (genvar g = 0; g < NumSrc; g++) begin : g_mon
    clk_loss_activity_mon #(.WIN_CYCLES(WIN_CYCLES)) u_mon (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .edge_i (edge_vec[g]),
      .dead_o (dead_vec[g])
    );
  end

  clk_loss_select_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_dead_i (dead_vec[0]),
    .fb_dead_i  (dead_vec[1]),
    .ext_mode_i (ext_mode_i),
    .loc_en_i   (loc_en_i),
    .irq_en_i   (irq_en_i),
    .scm_ok_i   (scm_ok_i),
    .sel_o      (sel),
    .irq_o      (irq_o),
    .ref_lost_o (ref_lost_o),
    .pll_lost_o (pll_lost_o)
  );

  assign sel_o         = sel;
  assign rst_release_o = ~|dead_vec;
endmodule

// File: rtl/clk_loss_supervisor_chk.sv
module clk_loss_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_mode_i,
  input logic       loc_en_i,
  input logic       irq_en_i,
  input logic [1:0] sel_o,
  input logic       irq_o,
  input logic       ref_lost_o,
  input logic       pll_lost_o
);
  AST_SCM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o == 2'b10 |=> sel_o[1]);  // R3
  AST_STATIC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o == 2'b11 |=> sel_o == 2'b11);  // R6
  AST_REF_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_lost_o) |-> sel_o[1]);  // R5
  AST_PLL_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pll_lost_o) && !ref_lost_o) |-> sel_o == 2'b01);  // R4
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i && loc_en_i && !ext_mode_i));  // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_o);  // R7
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_lost_o || pll_lost_o) |=> $past(ref_lost_o) <= ref_lost_o && $past(pll_lost_o) <= pll_lost_o);  // R8
endmodule

bind clk_loss_supervisor clk_loss_supervisor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_mode_i (ext_mode_i),
  .loc_en_i   (loc_en_i),
  .irq_en_i   (irq_en_i),
  .sel_o      (sel_o),
  .irq_o      (irq_o),
  .ref_lost_o (ref_lost_o),
  .pll_lost_o (pll_lost_o)
);

// File: tb/clk_loss_supervisor_bench.sv
module clk_loss_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 256;

  typedef struct {
    string      tag;
    logic [1:0] sel;
    logic       irq;
    logic       rl;
    logic       pl;
    logic       rel;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_e = 1'b1, fb_e = 1'b1, ext = 1'b0, loc = 1'b1, ien = 1'b1, scm = 1'b1;
  logic [1:0] sel;
  logic irq, rl, pl, rel;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_loss_supervisor #(.WIN_CYCLES(WIN)) u_clk_loss_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_e), .fb_edge_i(fb_e),
    .ext_mode_i(ext), .loc_en_i(loc), .irq_en_i(ien), .scm_ok_i(scm),
    .sel_o(sel), .irq_o(irq), .ref_lost_o(rl), .pll_lost_o(pl),
    .rst_release_o(rel)
  );

  // monitor: compare queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if ({sel, irq, rl, pl, rel} !== {e.sel, e.irq, e.rl, e.pl, e.rel}) begin
          n_fail++;
          $display("FAIL %s: sel/irq/rl/pl/rel actual %b %b %b %b %b expected %b %b %b %b %b",
                   e.tag, sel, irq, rl, pl, rel, e.sel, e.irq, e.rl, e.pl, e.rel);
        end
      end
    end
  end

  task automatic expect_out(string tag, logic [1:0] s, logic i, logic r, logic p, logic re);
    exp_t e;
    e.tag = tag; e.sel = s; e.irq = i; e.rl = r; e.pl = p; e.rel = re;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic x, logic l, logic ie, logic so);
    @(negedge clk);
    rst_n = 1'b0; ref_e = 1'b1; fb_e = 1'b1;
    ext = x; loc = l; ien = ie; scm = so;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    // R1
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    tick(2); expect_out("R1 pll-mode reset", 2'b00, 0, 0, 0, 1);
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    tick(2); expect_out("R1 ext-mode reset", 2'b01, 0, 0, 0, 1);

    // R4 PLL loss, plus R2/R10 window boundaries and R7 irq
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    tick(2); fb_e = 1'b0;
    tick(WIN-1); expect_out("R2 R10 before window", 2'b00, 0, 0, 0, 1);
    tick(1);     expect_out("R10 dead at window", 2'b00, 0, 0, 0, 0);
    tick(1);     expect_out("R4 R7 failover", 2'b01, 1, 0, 1, 0);
    fb_e = 1'b1;
    tick(1);     expect_out("R10 release back", 2'b01, 1, 0, 1, 1);
    tick(20);    expect_out("R4 R8 latched after recovery", 2'b01, 1, 0, 1, 1);

    // R3 reference loss, irq disabled
    do_reset(1'b0, 1'b1, 1'b0, 1'b1);
    tick(2); ref_e = 1'b0;
    tick(WIN);   expect_out("R2 ref not yet acted", 2'b00, 0, 0, 0, 0);
    tick(1);     expect_out("R3 R7 to scm no irq", 2'b10, 0, 1, 0, 0);
    ref_e = 1'b1;
    tick(20);    expect_out("R3 R8 stays scm", 2'b10, 0, 1, 0, 1);

    // R5 simultaneous
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    tick(2); ref_e = 1'b0; fb_e = 1'b0;
    tick(WIN+1); expect_out("R5 simultaneous", 2'b10, 1, 1, 1, 0);

    // R5 PLL first then reference
    do_reset(1'b0, 1'b1, 1'b1, 1'b1);
    tick(2); fb_e = 1'b0;
    tick(WIN+1); expect_out("R5 pll first", 2'b01, 1, 0, 1, 0);
    ref_e = 1'b0;
    tick(WIN+1); expect_out("R5 then ref", 2'b10, 1, 1, 1, 0);

    // R6 double failure with scm unhealthy
    do_reset(1'b0, 1'b1, 1'b1, 1'b0);
    tick(2); ref_e = 1'b0; fb_e = 1'b0;
    tick(WIN+1); expect_out("R6 static", 2'b11, 1, 1, 1, 0);
    ref_e = 1'b1; fb_e = 1'b1; scm = 1'b1;
    tick(10);    expect_out("R6 static holds", 2'b11, 1, 1, 1, 1);

    // R6 scm health drops while in scm
    do_reset(1'b0, 1'b1, 1'b0, 1'b1);
    tick(2); ref_e = 1'b0;
    tick(WIN+1); expect_out("R6 in scm", 2'b10, 0, 1, 0, 0);
    scm = 1'b0;
    tick(1);     expect_out("R6 scm drop", 2'b11, 0, 1, 0, 0);

    // R9 external mode
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    tick(2); ref_e = 1'b0; fb_e = 1'b0;
    tick(WIN+5); expect_out("R9 ext ignores loss", 2'b01, 0, 0, 0, 0);

    // R9 detection disabled
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    tick(2); ref_e = 1'b0; fb_e = 1'b0;
    tick(WIN+5); expect_out("R9 disabled ignores loss", 2'b00, 0, 0, 0, 0);

    tick(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule